// File: doc/BRIEF.md
# Lockable SMRAM Access Decoder

This block keeps the system-management RAM control state and classifies each memory request as bound for DRAM, bound for the downstream hub interface, or unrelated to SMRAM. Two protected regions are decoded. The first is a fixed 128 KB compatible window starting at A0000h. The second is a top segment that ends at the top-of-low-memory value and whose length is chosen by a two-bit size code.

Software programs an 8-bit control register and a separate lock register through a simple configuration write/read port. Once the lock is set, the fields that shape the protected regions and the open override are frozen until reset. The request path is purely combinational: the route for a request is valid in the same cycle as its address, SMM flag and code flag.

Top module: `smram_route_top`

## Requirements
- R1: After synchronous reset the control register reads 00h and the lock register reads 00h.
- R2: A write at configuration offset 9Eh loads the control register, and a read there returns it. Bit 7 always reads 0. Bit 6 is open, bit 5 is closed, bit 4 is a plain storage bit, bit 3 is the global enable, bits 2:1 are the segment size code, and bit 0 is the segment enable. A read at any offset other than 9Eh and 9Fh returns 0, and a write at any such offset changes nothing.
- R3: The lock is bit 0 of offset 9Fh. Writing 1 sets it, but only while the global enable is 1. Writing 0 has no effect, and only reset clears it.
- R4: While the lock is set, writes leave bits 6, 3, 2:1 and 0 unchanged, while bits 5 and 4 stay writable.
- R5: With the global enable at 1, a request in [A0000h, C0000h) routes to DRAM when it carries the SMM flag and to the hub when it does not. The route encoding is 0 for none, 1 for DRAM and 2 for hub.
- R6: The top segment is active when bits 3 and 0 are both 1. It covers [base, top), where base is top minus (128 KB shifted left by the size code) and is clamped to 0 when that would underflow. Inside it, SMM requests route to DRAM and all other requests route to the hub. The compatible window takes precedence where the two overlap.
- R7: While the open bit is 1 and the lock is 0, requests without the SMM flag to an active region route to DRAM. Once the lock is set, the open bit no longer grants this access.
- R8: With the closed bit at 1, data requests (code flag 0) to the compatible window route to the hub, even when the SMM flag or the open bit is set. Code requests there are not affected, and the closed bit has no effect on the top segment.
- R9: With the global enable at 0, every request routes to none (0). Bit 4 never affects a route.
- R10: A request outside both active regions routes to none (0) in the same cycle as it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| tolm | input | ADDR_W | Top of low memory, exclusive byte address |
| req_addr | input | ADDR_W | Request byte address |
| req_smm | input | 1 | Request carries SMM decode |
| req_code | input | 1 | 1 for a code fetch, 0 for a data reference |
| route | output | 2 | 0 none, 1 DRAM, 2 hub |

## Verification
The open override and the closed restriction can apply to the same request: a data reference to the compatible window with both bits set. The bench sweeps all 128 writable control patterns, and for each pattern it runs every combination of the SMM and code flags at both edges of both regions. Every route is compared with an arithmetic model, so the cases where both bits are set are judged by the rule that closed wins for data. A second collision comes from register writes that arrive while the lock is set. The bench provokes it by writing a control value immediately after locking and reading back to confirm which fields changed and which held.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef struct packed {
        logic       rsv;
        logic       open_en;
        logic       closed_en;
        logic       spare;
        logic       glob_en;
        logic [1:0] seg_code;
        logic       seg_en;
    } smram_ctrl_t;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_DRAM = 2'd1,
        ROUTE_HUB  = 2'd2
    } route_e;

    localparam logic [31:0] SEG_UNIT_BYTES = 32'h0002_0000;

    function automatic logic [31:0] seg_bytes(input logic [1:0] code);
        return SEG_UNIT_BYTES << code;
    endfunction

endpackage

// File: rtl/smram_ctrl_regs.sv
module smram_ctrl_regs
    import smram_pkg::*;
#(
    parameter logic [7:0] CTRL_OFS = 8'h9E,
    parameter logic [7:0] LOCK_OFS = 8'h9F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output smram_ctrl_t ctrl,
    output logic        locked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            locked <= 1'b0;
        end else if (wr_en) begin
            if (addr == CTRL_OFS) begin
                ctrl.closed_en <= wdata[5];
                ctrl.spare     <= wdata[4];
                if (!locked) begin
                    ctrl.open_en  <= wdata[6];
                    ctrl.glob_en  <= wdata[3];
                    ctrl.seg_code <= wdata[2:1];
                    ctrl.seg_en   <= wdata[0];
                end
            end
            if (addr == LOCK_OFS && wdata[0] && ctrl.glob_en)
                locked <= 1'b1;
        end
    end

    always_comb begin
        if (addr == CTRL_OFS)      rdata = ctrl;
        else if (addr == LOCK_OFS) rdata = {7'd0, locked};
        else                       rdata = 8'd0;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R3

    AST_LOCK_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ctrl.glob_en)); // R3

    AST_FROZEN_FIELDS: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(ctrl.open_en) && $stable(ctrl.glob_en)
                    && $stable(ctrl.seg_code) && $stable(ctrl.seg_en))); // R4

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl.rsv == 1'b0); // R2

endmodule

// File: rtl/smram_window.sv
module smram_window #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    assign hit = (addr >= base) && (addr < limit);
endmodule

// File: rtl/smram_route_top.sv
module smram_route_top
    import smram_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter logic [7:0]  CTRL_OFS     = 8'h9E,
    parameter logic [7:0]  LOCK_OFS     = 8'h9F,
    parameter logic [31:0] COMPAT_BASE  = 32'h000A_0000,
    parameter logic [31:0] COMPAT_BYTES = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] tolm,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_smm,
    input  logic              req_code,
    output logic [1:0]        route
);

    localparam logic [ADDR_W-1:0] CMP_LO = ADDR_W'(COMPAT_BASE);
    localparam logic [ADDR_W-1:0] CMP_HI = ADDR_W'(COMPAT_BASE + COMPAT_BYTES);

    smram_ctrl_t       ctrl;
    logic              locked;
    logic [ADDR_W-1:0] seg_len;
    logic [ADDR_W-1:0] seg_base;
    logic              in_compat;
    logic              in_seg;
    logic              open_live;
    logic              visible;
    route_e            route_q;

    smram_ctrl_regs #(.CTRL_OFS(CTRL_OFS), .LOCK_OFS(LOCK_OFS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl(ctrl), .locked(locked)
    );

    assign seg_len  = ADDR_W'(seg_bytes(ctrl.seg_code));
    assign seg_base = (tolm >= seg_len) ? (tolm - seg_len) : '0;

    smram_window #(.ADDR_W(ADDR_W)) u_compat_win (
        .base(CMP_LO), .limit(CMP_HI), .addr(req_addr), .hit(in_compat)
    );

    smram_window #(.ADDR_W(ADDR_W)) u_seg_win (
        .base(seg_base), .limit(tolm), .addr(req_addr), .hit(in_seg)
    );

    assign open_live = ctrl.open_en & ~locked;
    assign visible   = req_smm | open_live;

    always_comb begin
        route_q = ROUTE_NONE;
        if (ctrl.glob_en) begin
            if (in_compat) begin
                if (visible && !(ctrl.closed_en && !req_code)) route_q = ROUTE_DRAM;
                else                                           route_q = ROUTE_HUB;
            end else if (in_seg && ctrl.seg_en) begin
                route_q = visible ? ROUTE_DRAM : ROUTE_HUB;
            end
        end
    end

    assign route = route_q;

    AST_CLOSED_DATA: assert property (@(posedge clk) disable iff (rst)
        (ctrl.glob_en && ctrl.closed_en && in_compat && !req_code)
        |-> route == ROUTE_HUB); // R8

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl.glob_en |-> route == ROUTE_NONE); // R9

    AST_LOCKED_NO_OPEN: assert property (@(posedge clk) disable iff (rst)
        (locked && !req_smm && (in_compat || in_seg)) |-> route != ROUTE_DRAM); // R7

    AST_OUTSIDE_NONE: assert property (@(posedge clk) disable iff (rst)
        (!in_compat && !in_seg) |-> route == ROUTE_NONE); // R10

endmodule

// File: tb/smram_route_top_tb.sv
module smram_route_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [31:0] tolm;
    logic [31:0] req_addr;
    logic        req_smm;
    logic        req_code;
    logic [1:0]  route;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    smram_route_top u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tolm(tolm),
        .req_addr(req_addr), .req_smm(req_smm), .req_code(req_code), .route(route)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [1:0] model(input logic [7:0] c, input logic lk,
                                         input logic [31:0] t, input logic [31:0] a,
                                         input logic s, input logic cd);
        logic [31:0] sz, base;
        logic inc, ins, vis;
        sz   = 32'h0002_0000 << c[2:1];
        base = (t >= sz) ? t - sz : 32'd0;
        inc  = (a >= 32'h000A_0000) && (a < 32'h000C_0000);
        ins  = (a >= base) && (a < t);
        vis  = s | (c[6] & ~lk);
        if (!c[3]) return 2'd0;
        if (inc) return (vis && !(c[5] && !cd)) ? 2'd1 : 2'd2;
        if (ins && c[0]) return vis ? 2'd1 : 2'd2;
        return 2'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] c, input logic lk,
                                     input logic [31:0] t, input logic [31:0] a,
                                     input logic s, input logic cd);
        logic inc;
        inc = (a >= 32'h000A_0000) && (a < 32'h000C_0000);
        if (!c[3]) return "R9";
        if (inc && c[5] && !cd) return "R8";
        if (!s && c[6] && !lk && model(c, lk, t, a, s, cd) == 2'd1) return "R7";
        if (inc) return "R5";
        if (model(c, lk, t, a, s, cd) != 2'd0) return "R6";
        return "R10";
    endfunction

    task automatic probe(input logic [7:0] c, input logic lk, input logic [31:0] a,
                         input logic s, input logic cd);
        @(negedge clk);
        req_addr = a; req_smm = s; req_code = cd;
        #1 chk(tag_of(c, lk, tolm, a, s, cd), {30'd0, route}, {30'd0, model(c, lk, tolm, a, s, cd)});
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_addr = 8'h9E; cfg_wdata = 8'd0;
        tolm = 32'h0100_0000; req_addr = 32'd0; req_smm = 1'b0; req_code = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        cfg_read(8'h9E, rd); chk("R1", rd, 8'h00);
        cfg_read(8'h9F, rd); chk("R1", rd, 8'h00);

        // R2 reserved bit and foreign offsets
        cfg_write(8'h9E, 8'hFF);
        cfg_read(8'h9E, rd); chk("R2", rd, 8'h7F);
        cfg_write(8'h9D, 8'h00);
        cfg_read(8'h9E, rd); chk("R2", rd, 8'h7F);
        cfg_read(8'h9D, rd); chk("R2", rd, 8'h00);

        // Sweep all writable patterns, two memory tops
        for (int ti = 0; ti < 2; ti++) begin
            tolm = (ti == 0) ? 32'h0100_0000 : 32'h0010_0000;
            for (int c = 0; c < 128; c++) begin
                logic [7:0] cv;
                logic [31:0] sz, base;
                logic [31:0] addrs [9];
                cv = 8'(c);
                cfg_write(8'h9E, cv);
                cfg_read(8'h9E, rd); chk("R2", rd, {1'b0, cv[6:0]});
                sz   = 32'h0002_0000 << cv[2:1];
                base = (tolm >= sz) ? tolm - sz : 32'd0;
                addrs[0] = 32'h0009_FFFF; addrs[1] = 32'h000A_0000;
                addrs[2] = 32'h000B_FFFF; addrs[3] = 32'h000C_0000;
                addrs[4] = (base == 0) ? 32'd0 : base - 1; addrs[5] = base;
                addrs[6] = tolm - 1; addrs[7] = tolm; addrs[8] = 32'h0050_0000;
                for (int ai = 0; ai < 9; ai++)
                    for (int f = 0; f < 4; f++)
                        probe(cv, 1'b0, addrs[ai], f[0], f[1]);
            end
        end
        tolm = 32'h0100_0000;

        // R3 lock refused while global enable is 0
        cfg_write(8'h9E, 8'h40);
        cfg_write(8'h9F, 8'h01);
        cfg_read(8'h9F, rd); chk("R3", rd, 8'h00);

        // R3 writing zero does not lock, writing one with enable does
        cfg_write(8'h9E, 8'h4B);
        cfg_write(8'h9F, 8'h00);
        cfg_read(8'h9F, rd); chk("R3", rd, 8'h00);
        cfg_write(8'h9F, 8'h01);
        cfg_read(8'h9F, rd); chk("R3", rd, 8'h01);

        // R4 frozen fields versus writable bits 5 and 4
        cfg_write(8'h9E, 8'h30);
        cfg_read(8'h9E, rd); chk("R4", rd, 8'h7B);
        probe(8'h7B, 1'b1, 32'h000A_0000, 1'b1, 1'b0);   // R8 closed, data -> hub
        cfg_write(8'h9E, 8'h00);
        cfg_read(8'h9E, rd); chk("R4", rd, 8'h4B);
        // R7 open no longer effective once locked
        probe(8'h4B, 1'b1, 32'h000A_0000, 1'b0, 1'b1);
        @(negedge clk); req_addr = 32'h00FF_0000; req_smm = 1'b0; req_code = 1'b0;
        #1 chk("R7", {30'd0, route}, 32'd2);
        probe(8'h4B, 1'b1, 32'h000A_0000, 1'b1, 1'b1);

        // R3 clear attempt ignored, reset clears
        cfg_write(8'h9F, 8'h00);
        cfg_read(8'h9F, rd); chk("R3", rd, 8'h01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cfg_read(8'h9F, rd); chk("R3", rd, 8'h00);
        cfg_read(8'h9E, rd); chk("R1", rd, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule